// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This execution unit multiplies the low 32 bits of two 64-bit source operands and folds the 64-bit product into an accumulator. The accumulator is split across two architectural registers. Its upper half is the low word of HI and its lower half is the low word of LO. One decoder recognises a family of R-type instruction words (primary opcode zero). Each word selects signed or unsigned multiplication and one of four accumulator updates: replace with the product, add the product, replace with the negated product, or subtract the product. Each form may also return either half of the new accumulator, sign-extended, to a destination register. One further form adds the full signed product to all 64 bits of LO and leaves HI alone.

The surrounding pipeline supplies the instruction word, the two source values and the current HI and LO contents, and marks the cycle with `in_valid`. The result is registered. A small two-state controller governs the unit:
- **IDLE** moves to **RESULT** on `in_valid` and otherwise stays in **IDLE**.
- **RESULT** moves to **RESULT** again on a back-to-back `in_valid` and returns to **IDLE** otherwise.

While in **RESULT**, `done` is high and the destination write and the HI/LO update are presented together. An instruction word the decoder does not know still produces `done`, but it raises `illegal` and requests no write. The unit holds no architectural state of its own.

Top module: `mac_unit`

## Requirements
- R1: The accumulator is {HI[31:0], LO[31:0]}. Any update rewrites only HI[31:0] and LO[31:0]. `hi_out[63:32]` and `lo_out[63:32]` carry the incoming upper words unchanged. The LO-only form (R6) is the one exception.
- R2: The function code selects the multiplication type:
  - funct 101000: bits[10:6] bit 0 set means unsigned.
  - funct 011000 is signed and 011001 is unsigned.
  - Signed means both low words are read as two's-complement 32-bit values. Unsigned means both are read as unsigned 32-bit values.
  - The product is always 64 bits.
- R3: With funct 101000, these bits[10:6] codes replace the accumulator with the product (0 + product): 00100 (signed, low half returned), 00101 (unsigned, low), 01100 (signed, high), 01101 (unsigned, high).
- R4: With funct 101000, these bits[10:6] codes add the product to the accumulator: 00010 (signed, low returned), 00011 (unsigned, low), 01010 (signed, high), 01011 (unsigned, high).
- R5: Funct 101000 with bits[10:6] = 00000 and rd (bits[15:11]) = 0 adds the signed product to the accumulator and writes no destination register.
- R6: Funct 101001 with bits[10:6] = 00000 and rd = 0 adds the signed product to the full 64-bit LO. HI is left fully unchanged and no destination register is written.
- R7: With funct 011000 or 011001, bits[10:6] = 00011 replaces the accumulator with the negated product and returns the low half. Code 01011 does the same and returns the high half.
- R8: With funct 011000 or 011001, bits[10:6] = 00111 subtracts the product from the accumulator and returns the low half. Code 01111 does the same and returns the high half.
- R9: For the forms that return a value, `rd_data` is the selected 32-bit half of the new accumulator, sign-extended to 64 bits. `rd_addr` is the instruction's bits[15:11].
- R10: Addition and subtraction wrap modulo 2^64. There is no overflow indication and no saturation.
- R11: `done` is high exactly in the cycle after a cycle with `in_valid` high. `rd_we`, `hilo_we` and `illegal` are high only together with `done`.
- R12: Any other instruction word raises `illegal` with `done` and requests no write. This covers a non-zero primary opcode (bits[31:26]), any other function code, any other bits[10:6] value, and a non-zero rd on the R5 or R6 forms.
- R13: While reset (`rst_n` low) is applied, `done`, `illegal`, `rd_we` and `hilo_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 64 | First source register value |
| src_b | input | 64 | Second source register value |
| hi_in | input | 64 | Current HI register |
| lo_in | input | 64 | Current LO register |
| done | output | 1 | Result of the previous cycle's instruction is presented |
| illegal | output | 1 | That instruction was not recognised |
| rd_we | output | 1 | Destination register write enable |
| rd_addr | output | 5 | Destination register index |
| rd_data | output | 64 | Destination register write value |
| hilo_we | output | 1 | HI and LO write enable |
| hi_out | output | 64 | New HI value |
| lo_out | output | 64 | New LO value |

## Verification
The bound checker watches these properties on every cycle:
- the one-cycle relation between `in_valid` and `done`;
- that write enables and `illegal` appear only with `done`, and that `illegal` never comes with a write;
- the sign extension of `rd_data` and the match of `rd_addr` to the instruction's rd field;
- that the upper word of HI passes through.

The arithmetic itself can only be shown by the bench's scenarios against its reference model. That covers signed against unsigned products, the four accumulator updates, the LO-only form, half selection, modulo-2^64 wrap, and the exact set of words treated as illegal.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // function codes of the instruction family
    localparam logic [5:0] FN_MAC_ACC  = 6'b101000;
    localparam logic [5:0] FN_LO_ACC   = 6'b101001;
    localparam logic [5:0] FN_NEG_SGN  = 6'b011000;
    localparam logic [5:0] FN_NEG_UNS  = 6'b011001;

    // accumulator update kinds
    typedef enum logic [2:0] {
        OP_SET  = 3'd0,   // acc = 0 + product
        OP_ADD  = 3'd1,   // acc = acc + product
        OP_NEG  = 3'd2,   // acc = 0 - product
        OP_SUB  = 3'd3,   // acc = acc - product
        OP_LOAD = 3'd4    // LO  = LO + product, HI untouched
    } acc_op_e;

    typedef struct packed {
        logic    legal;
        acc_op_e op;
        logic    uns;
        logic    sel_hi;
        logic    wb;
    } mac_ctrl_t;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
    import mac_pkg::*;
(
    input  logic [5:0] opc,
    input  logic [4:0] rd,
    input  logic [4:0] sub,
    input  logic [5:0] fn,
    output mac_ctrl_t  ctrl
);

    always_comb begin
        ctrl = '{legal: 1'b0, op: OP_SET, uns: 1'b0, sel_hi: 1'b0, wb: 1'b0};
        if (opc == 6'd0) begin
            unique case (fn)
                FN_MAC_ACC: begin
                    case (sub)
                        5'b00000: if (rd == 5'd0) begin
                            ctrl.legal = 1'b1; ctrl.op = OP_ADD;
                        end
                        5'b00100: begin ctrl.legal = 1'b1; ctrl.op = OP_SET; ctrl.wb = 1'b1; end
                        5'b00101: begin ctrl.legal = 1'b1; ctrl.op = OP_SET; ctrl.wb = 1'b1; ctrl.uns = 1'b1; end
                        5'b01100: begin ctrl.legal = 1'b1; ctrl.op = OP_SET; ctrl.wb = 1'b1; ctrl.sel_hi = 1'b1; end
                        5'b01101: begin ctrl.legal = 1'b1; ctrl.op = OP_SET; ctrl.wb = 1'b1; ctrl.sel_hi = 1'b1; ctrl.uns = 1'b1; end
                        5'b00010: begin ctrl.legal = 1'b1; ctrl.op = OP_ADD; ctrl.wb = 1'b1; end
                        5'b00011: begin ctrl.legal = 1'b1; ctrl.op = OP_ADD; ctrl.wb = 1'b1; ctrl.uns = 1'b1; end
                        5'b01010: begin ctrl.legal = 1'b1; ctrl.op = OP_ADD; ctrl.wb = 1'b1; ctrl.sel_hi = 1'b1; end
                        5'b01011: begin ctrl.legal = 1'b1; ctrl.op = OP_ADD; ctrl.wb = 1'b1; ctrl.sel_hi = 1'b1; ctrl.uns = 1'b1; end
                        default: ;
                    endcase
                end
                FN_LO_ACC: begin
                    if (sub == 5'd0 && rd == 5'd0) begin
                        ctrl.legal = 1'b1; ctrl.op = OP_LOAD;
                    end
                end
                FN_NEG_SGN, FN_NEG_UNS: begin
                    ctrl.uns = (fn == FN_NEG_UNS);
                    case (sub)
                        5'b00011: begin ctrl.legal = 1'b1; ctrl.op = OP_NEG; ctrl.wb = 1'b1; end
                        5'b01011: begin ctrl.legal = 1'b1; ctrl.op = OP_NEG; ctrl.wb = 1'b1; ctrl.sel_hi = 1'b1; end
                        5'b00111: begin ctrl.legal = 1'b1; ctrl.op = OP_SUB; ctrl.wb = 1'b1; end
                        5'b01111: begin ctrl.legal = 1'b1; ctrl.op = OP_SUB; ctrl.wb = 1'b1; ctrl.sel_hi = 1'b1; end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  acc_op_e           op,
    input  logic              uns,
    input  logic              sel_hi,
    input  logic [HALF-1:0]   opnd_a,
    input  logic [HALF-1:0]   opnd_b,
    input  logic [XLEN-1:0]   hi_in,
    input  logic [XLEN-1:0]   lo_in,
    output logic [XLEN-1:0]   hi_nx,
    output logic [XLEN-1:0]   lo_nx,
    output logic [XLEN-1:0]   wb_val
);

    localparam int unsigned HALF = XLEN / 2;

    logic [XLEN-1:0] a_ext, b_ext, prod, acc, acc_nx;
    logic [HALF-1:0] half;

    // one 64x64 multiplier; the extension picks signed or unsigned
    assign a_ext = uns ? {{HALF{1'b0}}, opnd_a} : {{HALF{opnd_a[HALF-1]}}, opnd_a};
    assign b_ext = uns ? {{HALF{1'b0}}, opnd_b} : {{HALF{opnd_b[HALF-1]}}, opnd_b};
    assign prod  = a_ext * b_ext;
    assign acc   = {hi_in[HALF-1:0], lo_in[HALF-1:0]};

    always_comb begin
        case (op)
            OP_SET:  acc_nx = prod;
            OP_ADD:  acc_nx = acc + prod;
            OP_NEG:  acc_nx = {XLEN{1'b0}} - prod;
            OP_SUB:  acc_nx = acc - prod;
            default: acc_nx = acc;
        endcase

        if (op == OP_LOAD) begin
            hi_nx = hi_in;
            lo_nx = lo_in + prod;
        end else begin
            hi_nx = {hi_in[XLEN-1:HALF], acc_nx[XLEN-1:HALF]};
            lo_nx = {lo_in[XLEN-1:HALF], acc_nx[HALF-1:0]};
        end

        half   = sel_hi ? acc_nx[XLEN-1:HALF] : acc_nx[HALF-1:0];
        wb_val = {{HALF{half[HALF-1]}}, half};
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [XLEN-1:0] hi_in,
    input  logic [XLEN-1:0] lo_in,
    output logic            done,
    output logic            illegal,
    output logic            rd_we,
    output logic [4:0]      rd_addr,
    output logic [XLEN-1:0] rd_data,
    output logic            hilo_we,
    output logic [XLEN-1:0] hi_out,
    output logic [XLEN-1:0] lo_out
);

    localparam int unsigned HALF = XLEN / 2;

    typedef enum logic [0:0] {
        S_IDLE   = 1'b0,
        S_RESULT = 1'b1
    } state_e;

    state_e          state_q, state_d;
    mac_ctrl_t       ctrl;
    logic [XLEN-1:0] hi_nx, lo_nx, wb_val;
    logic            legal_q, wb_q;
    logic [4:0]      rd_q;
    logic [XLEN-1:0] wb_q_val, hi_q, lo_q;

    // register-index and upper operand bits carry no meaning here
    logic unused_fields;
    assign unused_fields = ^{instr[25:16], src_a[XLEN-1:HALF], src_b[XLEN-1:HALF]};

    mac_decode u_dec (
        .opc  (instr[31:26]),
        .rd   (instr[15:11]),
        .sub  (instr[10:6]),
        .fn   (instr[5:0]),
        .ctrl (ctrl)
    );

    mac_datapath #(.XLEN(XLEN)) u_dp (
        .op     (ctrl.op),
        .uns    (ctrl.uns),
        .sel_hi (ctrl.sel_hi),
        .opnd_a (src_a[HALF-1:0]),
        .opnd_b (src_b[HALF-1:0]),
        .hi_in  (hi_in),
        .lo_in  (lo_in),
        .hi_nx  (hi_nx),
        .lo_nx  (lo_nx),
        .wb_val (wb_val)
    );

    // next state
    always_comb begin
        unique case (state_q)
            S_IDLE:   state_d = in_valid ? S_RESULT : S_IDLE;
            S_RESULT: state_d = in_valid ? S_RESULT : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            legal_q  <= 1'b0;
            wb_q     <= 1'b0;
            rd_q     <= 5'd0;
            wb_q_val <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
        end else if (in_valid) begin
            legal_q  <= ctrl.legal;
            wb_q     <= ctrl.wb;
            rd_q     <= instr[15:11];
            wb_q_val <= wb_val;
            hi_q     <= hi_nx;
            lo_q     <= lo_nx;
        end
    end

    // outputs
    always_comb begin
        done    = (state_q == S_RESULT);
        illegal = done && !legal_q;
        rd_we   = done && legal_q && wb_q;
        hilo_we = done && legal_q;
        rd_addr = rd_q;
        rd_data = wb_q_val;
        hi_out  = hi_q;
        lo_out  = lo_q;
    end

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [4:0]  instr_rd,
    input logic [31:0] hi_in_up,
    input logic        done,
    input logic        illegal,
    input logic        rd_we,
    input logic [4:0]  rd_addr,
    input logic [63:0] rd_data,
    input logic        hilo_we,
    input logic [31:0] hi_out_up
);

    assert_done_after_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    assert_quiet_without_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);

    assert_writes_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we || hilo_we || illegal) |-> done);

    assert_illegal_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!rd_we && !hilo_we));

    assert_rd_sign_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> (rd_data[63:32] == {32{rd_data[31]}}));

    assert_rd_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> (rd_addr == $past(instr_rd)));

    assert_hi_upper_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hilo_we |-> (hi_out_up == $past(hi_in_up)));

    assert_reset_quiet_R13: assert property (@(posedge clk)
        !rst_n |=> (!done && !rd_we && !hilo_we && !illegal));

endmodule

bind mac_unit mac_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr_rd  (instr[15:11]),
    .hi_in_up  (hi_in[63:32]),
    .done      (done),
    .illegal   (illegal),
    .rd_we     (rd_we),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .hilo_we   (hilo_we),
    .hi_out_up (hi_out[63:32])
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] src_a, src_b, hi_in, lo_in;
    logic        done, illegal, rd_we, hilo_we;
    logic [4:0]  rd_addr;
    logic [63:0] rd_data, hi_out, lo_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    mac_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .hi_in(hi_in), .lo_in(lo_in),
        .done(done), .illegal(illegal), .rd_we(rd_we), .rd_addr(rd_addr),
        .rd_data(rd_data), .hilo_we(hilo_we), .hi_out(hi_out), .lo_out(lo_out)
    );

    typedef struct {
        bit          done;
        bit          bad;
        bit          wr;
        logic [4:0]  rd;
        logic [63:0] rdv;
        logic [63:0] hi;
        logic [63:0] lo;
        string       tag;
    } exp_t;

    exp_t expq[$];
    logic [63:0] last_hi = 0, last_lo = 0;

    function automatic logic [31:0] mk(logic [5:0] fn, logic [4:0] sa, logic [4:0] rd);
        return {6'd0, 5'd3, 5'd4, rd, sa, fn};
    endfunction

    // behavioural reference
    function automatic exp_t model(bit v, logic [31:0] ins, logic [63:0] a, logic [63:0] b,
                                   logic [63:0] hi, logic [63:0] lo, string extra);
        exp_t e;
        int mode = 0;        // 1 set, 2 add, 3 neg, 4 sub, 5 lo-only
        bit usg = 0, hs = 0, wr = 0;
        logic [5:0] fn = ins[5:0];
        logic [4:0] sa = ins[10:6];
        logic [4:0] rd = ins[15:11];
        logic [63:0] p, acc, n;
        logic [31:0] half;
        longint sx, sy;
        e.done = v; e.bad = 0; e.wr = 0; e.rd = rd; e.rdv = 0; e.hi = 0; e.lo = 0; e.tag = "R12";
        if (!v) return e;
        if (ins[31:26] == 6'd0) begin
            if (fn == 6'h28) begin
                if (sa == 5'd0 && rd == 5'd0) mode = 2;
                else if (sa inside {5'b00100, 5'b00101, 5'b01100, 5'b01101,
                                    5'b00010, 5'b00011, 5'b01010, 5'b01011}) begin
                    mode = sa[1] ? 2 : 1; usg = sa[0]; hs = sa[3]; wr = 1;
                end
            end else if (fn == 6'h29) begin
                if (sa == 5'd0 && rd == 5'd0) mode = 5;
            end else if (fn == 6'h18 || fn == 6'h19) begin
                if (sa inside {5'b00011, 5'b01011, 5'b00111, 5'b01111}) begin
                    mode = sa[2] ? 4 : 3; usg = fn[0]; hs = sa[3]; wr = 1;
                end
            end
        end
        if (mode == 0) begin e.bad = 1; return e; end
        sx = longint'(signed'(a[31:0]));
        sy = longint'(signed'(b[31:0]));
        p = usg ? ({32'd0, a[31:0]} * {32'd0, b[31:0]}) : 64'(sx * sy);
        acc = {hi[31:0], lo[31:0]};
        case (mode)
            1: n = p;
            2: n = acc + p;
            3: n = 64'd0 - p;
            default: n = acc - p;
        endcase
        e.wr = wr;
        if (mode == 5) begin
            e.hi = hi; e.lo = lo + p;
        end else begin
            e.hi = {hi[63:32], n[63:32]}; e.lo = {lo[63:32], n[31:0]};
        end
        half = hs ? n[63:32] : n[31:0];
        e.rdv = {{32{half[31]}}, half};
        case (mode)
            1: e.tag = "R3";
            2: e.tag = wr ? "R4" : "R5";
            3: e.tag = "R7";
            4: e.tag = "R8";
            default: e.tag = "R6";
        endcase
        e.tag = {e.tag, " R2", extra};
        return e;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // one clock: compare last cycle's expectation, then drive the next input
    task automatic step(bit v, logic [31:0] ins, logic [63:0] a, logic [63:0] b,
                        logic [63:0] hi, logic [63:0] lo, string extra);
        exp_t e;
        @(negedge clk);
        if (expq.size() > 0) begin
            e = expq.pop_front();
            chk("R11", "done", 64'(done), 64'(e.done));
            if (e.done) begin
                chk({e.tag, " R12"}, "illegal", 64'(illegal), 64'(e.bad));
                chk({e.tag, " R9"}, "rd_we", 64'(rd_we), 64'(!e.bad && e.wr));
                chk({e.tag, " R11"}, "hilo_we", 64'(hilo_we), 64'(!e.bad));
                if (!e.bad) begin
                    if (e.wr) begin
                        chk({e.tag, " R9"}, "rd_addr", 64'(rd_addr), 64'(e.rd));
                        chk({e.tag, " R9"}, "rd_data", rd_data, e.rdv);
                    end
                    chk({e.tag, " R1"}, "hi_out", hi_out, e.hi);
                    chk({e.tag, " R1"}, "lo_out", lo_out, e.lo);
                    last_hi = e.hi; last_lo = e.lo;
                end
            end
        end
        in_valid = v; instr = ins; src_a = a; src_b = b; hi_in = hi; lo_in = lo;
        expq.push_back(model(v, ins, a, b, hi, lo, extra));
    endtask

    task automatic idle();
        step(0, 32'd0, 64'd0, 64'd0, 64'd0, 64'd0, "");
    endtask

    localparam int NC = 18;
    logic [5:0] fns [NC] = '{6'h28, 6'h28, 6'h28, 6'h28, 6'h28, 6'h28, 6'h28, 6'h28, 6'h28,
                             6'h29, 6'h18, 6'h18, 6'h18, 6'h18, 6'h19, 6'h19, 6'h19, 6'h19};
    logic [4:0] sas [NC] = '{5'b00100, 5'b00101, 5'b01100, 5'b01101, 5'b00010, 5'b00011,
                             5'b01010, 5'b01011, 5'b00000, 5'b00000,
                             5'b00011, 5'b01011, 5'b00111, 5'b01111,
                             5'b00011, 5'b01011, 5'b00111, 5'b01111};

    initial begin
        rst_n = 0; in_valid = 0; instr = 0; src_a = 0; src_b = 0; hi_in = 0; lo_in = 0;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13", "done", 64'(done), 64'd0);
        chk("R13", "illegal", 64'(illegal), 64'd0);
        chk("R13", "rd_we", 64'(rd_we), 64'd0);
        chk("R13", "hilo_we", 64'(hilo_we), 64'd0);
        rst_n = 1;
        expq.push_back(model(0, 0, 0, 0, 0, 0, ""));

        // directed: every legal code with signed-sensitive operands (R2..R8)
        for (int i = 0; i < NC; i++) begin
            logic [4:0] rdi = (i == 8 || i == 9) ? 5'd0 : 5'(i + 1);
            step(1, mk(fns[i], sas[i], rdi), 64'hABCD_0000_FFFF_FFFD, 64'h1234_5678_0000_0007,
                 64'hDEAD_BEEF_0000_0011, 64'hCAFE_F00D_8000_0022, "");
        end
        idle();
        for (int i = 0; i < NC; i++) begin
            logic [4:0] rdi = (i == 8 || i == 9) ? 5'd0 : 5'd31;
            step(1, mk(fns[i], sas[i], rdi), 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
                 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF, "");
        end

        // R10: wrap of accumulate and subtract
        step(1, mk(6'h28, 5'b00010, 5'd2), 64'd2, 64'd1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, " R10");
        step(1, mk(6'h28, 5'b01010, 5'd2), 64'd2, 64'd1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, " R10");
        step(1, mk(6'h18, 5'b01111, 5'd2), 64'd1, 64'd1, 64'd0, 64'd0, " R10");
        step(1, mk(6'h29, 5'd0, 5'd0), 64'd1, 64'd1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, " R10");
        idle(); idle();

        // R12: unrecognised words
        step(1, {6'd1, mk(6'h28, 5'b00100, 5'd1)} [31:0] | 32'h0400_0000, 64'd5, 64'd6, 64'd1, 64'd2, "");
        step(1, mk(6'h28, 5'b00001, 5'd1), 64'd5, 64'd6, 64'd1, 64'd2, "");
        step(1, mk(6'h28, 5'b00000, 5'd5), 64'd5, 64'd6, 64'd1, 64'd2, "");
        step(1, mk(6'h29, 5'b00000, 5'd3), 64'd5, 64'd6, 64'd1, 64'd2, "");
        step(1, mk(6'h29, 5'b00010, 5'd0), 64'd5, 64'd6, 64'd1, 64'd2, "");
        step(1, mk(6'h18, 5'b00000, 5'd1), 64'd5, 64'd6, 64'd1, 64'd2, "");
        step(1, mk(6'h19, 5'b00100, 5'd1), 64'd5, 64'd6, 64'd1, 64'd2, "");
        step(1, mk(6'h2A, 5'b00100, 5'd1), 64'd5, 64'd6, 64'd1, 64'd2, "");
        idle();

        // random mix, chained accumulator, gaps
        for (int k = 0; k < 600; k++) begin
            int idx = int'($urandom_range(0, NC - 1));
            logic [4:0] rdi = (idx == 8 || idx == 9) ? 5'd0 : 5'($urandom_range(0, 31));
            logic [63:0] hv = {$urandom, $urandom};
            logic [63:0] lv = {$urandom, $urandom};
            if ($urandom_range(0, 1) == 1) begin hv = last_hi; lv = last_lo; end
            if ($urandom_range(0, 5) == 0) idle();
            else step(1, mk(fns[idx], sas[idx], rdi), {$urandom, $urandom}, {$urandom, $urandom},
                      hv, lv, "");
        end
        idle(); idle();

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule